// File: doc/BRIEF.md
# Pipelined Tag Compare Memory

A single-port tag store for cache lookup. Every synchronous input is sampled on the rising edge of `clk_i`. A separately gated input data register holds the tag that the block compares against the word stored at the captured address. The equality result passes through a pipeline register, so it appears at the hit output one edge after the cycle that captured the address and tag.

The same held tag can be written back into the array in a fill cycle. A fill cycle writes the register's contents without sampling the data bus. This lets a miss be repaired with the tag that was just compared. Writes are either whole-word or per 9-bit lane. Read data is registered and is gated by an asynchronous output enable. The hit flag has its own asynchronous enable. Each three-state output is modelled as a value plus a drive-enable. The array depth is a parameter.

Top module: `tag_cmp_mem`

## Requirements
- R1: The block is selected only when `ce_ni`=0, `ce2_ni`=0 and `ce3_i`=1. In any other cycle, the array and the input data register are left unchanged, whatever the write and enable inputs are.
- R2: A selected cycle with `gw_ni`=0 writes all 18 bits at `addr_i`.
- R3: With `gw_ni`=1 and `bwe_ni`=0, `lane_we_ni[0]`=0 writes bits 8:0 and `lane_we_ni[1]`=0 writes bits 17:9, and the other lane keeps its old value. With `gw_ni`=1 and `bwe_ni`=1, nothing is written.
- R4: The input data register takes `data_i` only on an edge where the block is selected and `din_en_ni`=0.
- R5: In a selected write cycle with `din_en_ni`=1 (fill), the array receives the held register value and `data_i` is ignored. In a selected write cycle with `din_en_ni`=0, `data_i` is loaded and written.
- R6: For a selected non-write cycle captured at edge k, `match_o` after edge k+1 is 1 if the register equals the stored word and 0 if it differs. After edge k, `match_o` still shows the earlier result.
- R7: `match_oe_o` equals the inverse of `match_en_ni`, with no clock involved.
- R8: A deselected cycle captured at edge k drives `match_o` to 1 after edge k+1.
- R9: For a selected non-write cycle captured at edge k, `data_o` holds the stored word after edge k+1. `data_oe_o` is 1 only while `oe_ni`=0 and the previous captured cycle was such a read.
- R10: After reset, `match_o`=1, `data_oe_o`=0 and `data_o`=0, and the array reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the pipeline registers |
| addr_i | input | ADDR_W | Word address |
| data_i | input | DATA_W | Write data / compare tag |
| data_o | output | DATA_W | Registered read data |
| data_oe_o | output | 1 | Drive enable for data_o |
| oe_ni | input | 1 | Asynchronous data output enable, active low |
| ce_ni | input | 1 | Chip enable, active low |
| ce2_ni | input | 1 | Chip enable, active low |
| ce3_i | input | 1 | Chip enable, active high |
| gw_ni | input | 1 | Whole-word write, active low |
| bwe_ni | input | 1 | Lane write gate, active low |
| lane_we_ni | input | NUM_LANES | Per-lane write enables, active low |
| din_en_ni | input | 1 | Input data register load enable, active low |
| match_o | output | 1 | Registered hit flag |
| match_oe_o | output | 1 | Drive enable for match_o |
| match_en_ni | input | 1 | Asynchronous hit output enable, active low |

## Verification
The assertions assume that every synchronous input is stable and known around each rising edge, and that the array holds defined contents from time zero. The bench meets both conditions: it changes inputs only on falling edges, and it samples outputs 1 ns after a rising edge. No input is ever left unknown during a run. The clocked assertions are disabled while reset is asserted.

// File: rtl/tag_cmp_pkg.sv
package tag_cmp_pkg;
  typedef enum logic [1:0] {
    CYC_DESEL = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;
endpackage

// File: rtl/tag_cmp_ctrl.sv
module tag_cmp_ctrl #(
  parameter int NUM_LANES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ce_ni,
  input  logic                 ce2_ni,
  input  logic                 ce3_i,
  input  logic                 gw_ni,
  input  logic                 bwe_ni,
  input  logic [NUM_LANES-1:0] lane_we_ni,
  input  logic                 din_en_ni,
  output logic                 sel_o,
  output logic                 wr_o,
  output logic [NUM_LANES-1:0] lane_wr_o,
  output logic                 din_ld_o
);
  logic sel;
  assign sel      = !ce_ni && !ce2_ni && ce3_i;
  assign sel_o    = sel;
  assign din_ld_o = sel && !din_en_ni;
  assign wr_o     = |lane_wr_o;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign lane_wr_o[l] = sel && (!gw_ni || (!bwe_ni && !lane_we_ni[l]));
  end

  // R1
  desel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || ce2_ni || !ce3_i) |-> (!wr_o && !din_ld_o));
  // R3
  lane_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gw_ni && bwe_ni) |-> (lane_wr_o == '0));
endmodule

// File: rtl/tag_cmp_array.sv
module tag_cmp_array #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 18,
  parameter int LANE_W = 9,
  localparam int NUM_LANES = DATA_W / LANE_W,
  localparam int ADDR_W    = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LANES-1:0] lane_we_i,
  input  logic [ADDR_W-1:0]    waddr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [ADDR_W-1:0]    raddr_i,
  output logic [DATA_W-1:0]    rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  // simulation-only clear of the array
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (lane_we_i[l]) mem[waddr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
    end

    // R2 R3
    lane_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lane_we_i[l] |=> (mem[$past(waddr_i)][l*LANE_W +: LANE_W]
                        == $past(wdata_i[l*LANE_W +: LANE_W])));
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/tag_cmp_pipe.sv
module tag_cmp_pipe
  import tag_cmp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              din_ld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [DATA_W-1:0] din_o,
  output logic              match_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              rd_vld_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q, dout_q;
  cyc_e              cyc_q;
  logic              match_q, rd_vld_q;

  // stage 1: capture address, tag and cycle kind
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      din_q  <= '0;
      cyc_q  <= CYC_DESEL;
    end else begin
      if (sel_i)    addr_q <= addr_i;
      if (din_ld_i) din_q  <= data_i;
      cyc_q <= !sel_i ? CYC_DESEL : (wr_i ? CYC_WRITE : CYC_READ);
    end
  end

  // stage 2: register compare result and read data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q  <= 1'b1;
      dout_q   <= '0;
      rd_vld_q <= 1'b0;
    end else begin
      match_q  <= (cyc_q == CYC_DESEL) ? 1'b1 : (din_q == rdata_i);
      rd_vld_q <= (cyc_q == CYC_READ);
      if (cyc_q == CYC_READ) dout_q <= rdata_i;
    end
  end

  assign raddr_o  = addr_q;
  assign din_o    = din_q;
  assign match_o  = match_q;
  assign dout_o   = dout_q;
  assign rd_vld_o = rd_vld_q;

  // R4
  din_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !din_ld_i |=> $stable(din_q));
  // R8
  desel_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == CYC_DESEL) |=> match_q);
  // R9
  dout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != CYC_READ) |=> ($stable(dout_q) && !rd_vld_q));
endmodule

// File: rtl/tag_cmp_mem.sv
module tag_cmp_mem #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 18,
  parameter int LANE_W = 9,
  localparam int NUM_LANES = DATA_W / LANE_W,
  localparam int ADDR_W    = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    data_i,
  output logic [DATA_W-1:0]    data_o,
  output logic                 data_oe_o,
  input  logic                 oe_ni,
  input  logic                 ce_ni,
  input  logic                 ce2_ni,
  input  logic                 ce3_i,
  input  logic                 gw_ni,
  input  logic                 bwe_ni,
  input  logic [NUM_LANES-1:0] lane_we_ni,
  input  logic                 din_en_ni,
  output logic                 match_o,
  output logic                 match_oe_o,
  input  logic                 match_en_ni
);
  logic                 sel, wr, din_ld, rd_vld;
  logic [NUM_LANES-1:0] lane_wr;
  logic [ADDR_W-1:0]    raddr;
  logic [DATA_W-1:0]    rdata, din_q, wdata;

  tag_cmp_ctrl #(.NUM_LANES(NUM_LANES)) u_ctrl (
    .clk_i, .rst_ni, .ce_ni, .ce2_ni, .ce3_i, .gw_ni, .bwe_ni, .lane_we_ni, .din_en_ni,
    .sel_o(sel), .wr_o(wr), .lane_wr_o(lane_wr), .din_ld_o(din_ld)
  );

  // fill cycles write the held tag, others the bus
  assign wdata = din_ld ? data_i : din_q;

  tag_cmp_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_array (
    .clk_i, .rst_ni, .lane_we_i(lane_wr), .waddr_i(addr_i), .wdata_i(wdata),
    .raddr_i(raddr), .rdata_o(rdata)
  );

  tag_cmp_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pipe (
    .clk_i, .rst_ni, .sel_i(sel), .wr_i(wr), .din_ld_i(din_ld), .addr_i, .data_i,
    .rdata_i(rdata), .raddr_o(raddr), .din_o(din_q), .match_o, .dout_o(data_o),
    .rd_vld_o(rd_vld)
  );

  assign data_oe_o  = !oe_ni && rd_vld;
  assign match_oe_o = !match_en_ni;

  // R9
  dout_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !oe_ni);
endmodule

// File: tb/tag_cmp_mem_tb_top.sv
module tag_cmp_mem_tb_top;
  localparam int DEPTH = 256;
  localparam int DW    = 18;

  logic clk = 0, rst_n = 0;
  logic [7:0]  addr = 0;
  logic [DW-1:0] din = 0, dout;
  logic dout_oe, oe_n = 0;
  logic ce_n = 1, ce2_n = 0, ce3 = 1, gw_n = 1, bwe_n = 1, den_n = 1, men_n = 0;
  logic [1:0] lane_n = 2'b11;
  logic match, match_oe;

  int checks = 0, fails = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] ref_din = 0;

  always #2 clk = ~clk;

  tag_cmp_mem dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(din), .data_o(dout),
    .data_oe_o(dout_oe), .oe_ni(oe_n), .ce_ni(ce_n), .ce2_ni(ce2_n), .ce3_i(ce3),
    .gw_ni(gw_n), .bwe_ni(bwe_n), .lane_we_ni(lane_n), .din_en_ni(den_n),
    .match_o(match), .match_oe_o(match_oe), .match_en_ni(men_n)
  );

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // one cycle: drive on falling edge, update reference at rising edge, sample 1ns later
  task automatic step(input logic c1, c2, c3, g, b, input logic [1:0] ln, input logic dn,
                      input logic [7:0] a, input logic [DW-1:0] d);
    logic s, w;
    logic [DW-1:0] wd;
    @(negedge clk);
    ce_n = c1; ce2_n = c2; ce3 = c3; gw_n = g; bwe_n = b; lane_n = ln; den_n = dn;
    addr = a; din = d;
    @(posedge clk);
    s  = !c1 && !c2 && c3;
    w  = !g || (!b && ln != 2'b11);
    wd = !dn ? d : ref_din;
    if (s && w) begin
      if (!g || !ln[0]) ref_mem[a][8:0]  = wd[8:0];
      if (!g || !ln[1]) ref_mem[a][17:9] = wd[17:9];
    end
    if (s && !dn) ref_din = d;
    #1;
  endtask

  task automatic wr_gw(input logic [7:0] a, input logic [DW-1:0] d);
    step(0, 0, 1, 0, 1, 2'b11, 0, a, d);
  endtask
  task automatic wr_lane(input logic [7:0] a, input logic [DW-1:0] d, input logic b, input logic [1:0] ln);
    step(0, 0, 1, 1, b, ln, 0, a, d);
  endtask
  task automatic desel(input logic c1, c2, c3);
    step(c1, c2, c3, 0, 0, 2'b00, 0, 8'd3, 18'h15555);
  endtask
  task automatic rd_chk(input string req, input logic [7:0] a);
    desel(1, 0, 1);
    step(0, 0, 1, 1, 1, 2'b11, 1, a, 18'h0);
    chk({req, " oe before pipe edge"}, {17'b0, dout_oe}, 18'd0);
    desel(1, 0, 1);
    chk({req, " read data"}, dout, ref_mem[a]);
    chk({req, " read oe"}, {17'b0, dout_oe}, 18'd1);
  endtask
  task automatic cmp_chk(input string req, input logic [7:0] a, input logic [DW-1:0] d, input logic exp);
    desel(1, 0, 1);
    desel(1, 0, 1);
    step(0, 0, 1, 1, 1, 2'b11, 0, a, d);
    chk({req, " match held at edge k"}, {17'b0, match}, 18'd1);
    desel(1, 0, 1);
    chk({req, " match at edge k+1"}, {17'b0, match}, {17'b0, exp});
  endtask

  // R10
  task automatic t_reset();
    men_n = 1;
    #1;
    chk("R10 match", {17'b0, match}, 18'd1);
    chk("R10 data_oe", {17'b0, dout_oe}, 18'd0);
    chk("R10 data", dout, 18'd0);
    chk("R7 match_oe off", {17'b0, match_oe}, 18'd0);
    men_n = 0;
    #1;
    chk("R7 match_oe on", {17'b0, match_oe}, 18'd1);
  endtask

  // R2 R9 R10
  task automatic t_full_write();
    rd_chk("R10 zero array", 8'd200);
    wr_gw(8'd5, 18'h2A5A5);
    wr_gw(8'd0, 18'h3FFFF);
    wr_gw(8'd255, 18'h00001);
    rd_chk("R2 addr5", 8'd5);
    rd_chk("R2 addr0", 8'd0);
    rd_chk("R2 addr255", 8'd255);
    oe_n = 1;
    #1;
    chk("R9 oe gated", {17'b0, dout_oe}, 18'd0);
    oe_n = 0;
  endtask

  // R3
  task automatic t_lanes();
    wr_lane(8'd5, 18'h3FFFF, 0, 2'b10);
    rd_chk("R3 low lane", 8'd5);
    chk("R3 low lane value", ref_mem[5], 18'h2A5FF);
    wr_lane(8'd5, 18'h00000, 0, 2'b01);
    rd_chk("R3 high lane", 8'd5);
    wr_lane(8'd5, 18'h12345, 1, 2'b00);
    rd_chk("R3 bwe high no write", 8'd5);
  endtask

  // R1
  task automatic t_desel();
    wr_gw(8'd3, 18'h0BEEF);
    desel(1, 0, 1);
    desel(0, 1, 1);
    desel(0, 0, 0);
    rd_chk("R1 no write when deselected", 8'd3);
  endtask

  // R6 R8
  task automatic t_compare();
    cmp_chk("R6 hit", 8'd5, ref_mem[5], 1'b1);
    cmp_chk("R6 miss", 8'd5, ref_mem[5] ^ 18'h00100, 1'b0);
    desel(0, 0, 0);
    chk("R8 deselect match", {17'b0, match}, 18'd1);
    cmp_chk("R6 miss lane", 8'd0, 18'h1FFFF, 1'b0);
  endtask

  // R4 R5
  task automatic t_fill();
    cmp_chk("R6 miss before fill", 8'd7, 18'h1C3A7, 1'b0);
    step(1, 0, 1, 1, 1, 2'b11, 0, 8'd9, 18'h00F0F);
    step(0, 0, 1, 0, 1, 2'b11, 1, 8'd7, 18'h2FFFF);
    rd_chk("R5 fill writes held tag", 8'd7);
    chk("R4 R5 fill value", ref_mem[7], 18'h1C3A7);
    cmp_chk("R5 hit after fill", 8'd7, 18'h1C3A7, 1'b1);
    step(0, 0, 1, 1, 0, 2'b01, 1, 8'd7, 18'h00000);
    rd_chk("R5 lane fill", 8'd7);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1;
    t_full_write();
    t_lanes();
    t_desel();
    t_compare();
    t_fill();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule